// File: doc/BRIEF.md
# Fourth-order divisive recurrence evaluator

This block computes one term of an integer sequence whose first four terms are fixed at 2, 1, 3 and 4. Every later term is found by adding the three newest terms and dividing that sum by the term one place older than them, which is the oldest of the last four. A host places the wanted index k in a one-word location, pulses `start`, and the block reads k from that word. It then steps through the sequence while keeping the four newest terms in a shifting history. When it finishes, it overwrites the same word with the term and pulses `done`.

Each step adds three terms into an accumulator two bits wider than a term, so the sum cannot overflow. The sum then goes to a restoring divider that resolves one quotient bit per clock. The quotient is unsigned and truncated, and it enters the history as the newest term. Indices of four or less need no iteration and are answered at once with a flag raised. A zero divisor stops the evaluation, and the block writes an all-ones word.

Top module: `recur_eval`

## Requirements
- R1: After reset `busy`, `done`, `loc_we`, `err_div0` and `bad_index` are all 0.
- R2: When a start is accepted with k equal to 1, 2, 3 or 4, the result is 2, 1, 3 or 4 respectively. `bad_index` is 1 and `done` rises in the cycle after the start.
- R3: When a start is accepted with k = 0, the result is all ones, with `bad_index` = 1 and `done` in the cycle after the start.
- R4: For k > 4 the result is term k, where term(n+1) = (term(n) + term(n-1) + term(n-2)) / term(n-3) with truncating unsigned division. Expected values are k=5 gives 4, k=6 gives 11, k=7 gives 6, k=10 gives 1 and k=16 gives 5.
- R5: Completion is signalled by exactly one cycle with `loc_we` = 1, in the same cycle as `done`, with `loc_wdata` equal to the result. The location therefore holds the result in place of k.
- R6: If a step finds a zero divisor, the block stops, writes all ones and sets `err_div0`. With the given seeds, term 13 is 0, so any k of 17 or more ends this way.
- R7: `busy` is 1 from the cycle after an accepted start through the `done` cycle, and 0 after that. A `start` while `busy` is 1 is ignored.
- R8: `err_div0` and `bad_index` keep their values after `done` until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an evaluation (taken only when idle) |
| loc_rdata | input | DATA_W | Current content of the one-word location (k) |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| loc_we | output | 1 | Write strobe for the location |
| loc_wdata | output | DATA_W | Word written to the location |
| err_div0 | output | 1 | Last evaluation met a zero divisor |
| bad_index | output | 1 | Last evaluation had k of 4 or less |

## Verification
A corrupted history entry or a wrong quotient bit propagates into every later term. It therefore shows as a wrong written word only at `done`, which is up to (DATA_W+4) cycles per term after the fault. For this reason each index is checked against an independent model, and short and long indices are mixed. A wrong step counter shows as a result taken from the wrong position, such as 6 where 11 is expected. A broken zero-divisor test shows at once as a hang (caught by the wait limit) or as a missing all-ones write. Control faults around `start` show within one cycle as an extra `done`, a second write or an overwritten result.

// File: rtl/recur_pkg.sv
package recur_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_WAIT,
        ST_FINISH
    } ctl_state_e;

    localparam int HIST_DEPTH = 4;

    // Fixed opening terms, index 1 to 4; other indices give 0.
    function automatic logic [7:0] seed_term(input logic [2:0] idx);
        case (idx)
            3'd1:    return 8'd2;
            3'd2:    return 8'd1;
            3'd3:    return 8'd3;
            3'd4:    return 8'd4;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/recur_div.sv
module recur_div #(
    parameter int NUM_W = 18,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic             fin,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             run;
        logic             fin;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W:0]   rem;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] dvs;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [DEN_W:0] trial;

    always_comb begin
        s_d   = s_q;
        s_d.fin = 1'b0;
        trial = {s_q.rem[DEN_W-1:0], s_q.quo[NUM_W-1]};
        if (go && !s_q.run) begin
            s_d.run = 1'b1;
            s_d.cnt = '0;
            s_d.rem = '0;
            s_d.quo = dividend;
            s_d.dvs = divisor;
        end else if (s_q.run) begin
            if (trial >= {1'b0, s_q.dvs}) begin
                s_d.rem = trial - {1'b0, s_q.dvs};
                s_d.quo = {s_q.quo[NUM_W-2:0], 1'b1};
            end else begin
                s_d.rem = trial;
                s_d.quo = {s_q.quo[NUM_W-2:0], 1'b0};
            end
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == CNT_W'(NUM_W - 1)) begin
                s_d.run = 1'b0;
                s_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fin  = s_q.fin;
    assign quot = s_q.quo;

endmodule

// File: rtl/recur_win.sv
module recur_win
    import recur_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] new_term,
    output logic [DATA_W-1:0] taps [HIST_DEPTH]
);
    // taps[0] is the oldest entry, taps[HIST_DEPTH-1] the newest.
    logic [DATA_W-1:0] h_d [HIST_DEPTH];
    logic [DATA_W-1:0] h_q [HIST_DEPTH];

    always_comb begin
        for (int i = 0; i < HIST_DEPTH; i++) begin
            h_d[i] = h_q[i];
            if (load)
                h_d[i] = DATA_W'(seed_term(3'(i + 1)));
            else if (shift)
                h_d[i] = (i == HIST_DEPTH - 1) ? new_term : h_q[(i + 1) % HIST_DEPTH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < HIST_DEPTH; i++) h_q[i] <= '0;
        end else begin
            for (int i = 0; i < HIST_DEPTH; i++) h_q[i] <= h_d[i];
        end
    end

    assign taps = h_q;

endmodule

// File: rtl/recur_eval.sv
module recur_eval
    import recur_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] loc_rdata,
    output logic              busy,
    output logic              done,
    output logic              loc_we,
    output logic [DATA_W-1:0] loc_wdata,
    output logic              err_div0,
    output logic              bad_index
);
    localparam int SUM_W = DATA_W + 2;

    typedef struct packed {
        ctl_state_e        st;
        logic [DATA_W-1:0] k;
        logic [DATA_W-1:0] n;
        logic [DATA_W-1:0] result;
        logic              div0;
        logic              badidx;
    } ctl_t;

    ctl_t r_d, r_q;

    logic              win_load, win_shift, div_go, div_fin;
    logic [DATA_W-1:0] taps [HIST_DEPTH];
    logic [SUM_W-1:0]  sum3, quot;

    recur_win #(.DATA_W(DATA_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_load),
        .shift    (win_shift),
        .new_term (quot[DATA_W-1:0]),
        .taps     (taps)
    );

    assign sum3 = SUM_W'(taps[1]) + SUM_W'(taps[2]) + SUM_W'(taps[3]);

    recur_div #(.NUM_W(SUM_W), .DEN_W(DATA_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (sum3),
        .divisor  (taps[0]),
        .fin      (div_fin),
        .quot     (quot)
    );

    always_comb begin
        r_d       = r_q;
        win_load  = 1'b0;
        win_shift = 1'b0;
        div_go    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.k      = loc_rdata;
                    r_d.n      = DATA_W'(HIST_DEPTH);
                    r_d.div0   = 1'b0;
                    r_d.badidx = 1'b0;
                    win_load   = 1'b1;
                    if (loc_rdata <= DATA_W'(HIST_DEPTH)) begin
                        r_d.badidx = 1'b1;
                        r_d.result = (loc_rdata == '0) ? '1
                                   : DATA_W'(seed_term(loc_rdata[2:0]));
                        r_d.st     = ST_FINISH;
                    end else begin
                        r_d.st     = ST_CALC;
                    end
                end
            end
            ST_CALC: begin
                if (taps[0] == '0) begin
                    r_d.div0   = 1'b1;
                    r_d.result = '1;
                    r_d.st     = ST_FINISH;
                end else begin
                    div_go = 1'b1;
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (div_fin) begin
                    win_shift = 1'b1;
                    r_d.n     = r_q.n + 1'b1;
                    if (r_q.n + 1'b1 == r_q.k) begin
                        r_d.result = quot[DATA_W-1:0];
                        r_d.st     = ST_FINISH;
                    end else begin
                        r_d.st     = ST_CALC;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = (r_q.st == ST_FINISH);
    assign loc_we    = done;
    assign loc_wdata = r_q.result;
    assign err_div0  = r_q.div0;
    assign bad_index = r_q.badidx;

endmodule

// File: rtl/recur_eval_chk.sv
module recur_eval_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] loc_rdata,
    input logic              busy,
    input logic              done,
    input logic              loc_we,
    input logic [DATA_W-1:0] loc_wdata,
    input logic              err_div0,
    input logic              bad_index
);
    assert_seed_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && loc_rdata != '0 && loc_rdata <= DATA_W'(4))
        |=> (done && bad_index));

    assert_zero_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && loc_rdata == '0)
        |=> (done && bad_index && loc_wdata == {DATA_W{1'b1}}));

    assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        loc_we |=> !loc_we);

    assert_div0_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_div0) |-> (loc_wdata == {DATA_W{1'b1}}));

    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(err_div0) && $stable(bad_index)));

endmodule

bind recur_eval recur_eval_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .loc_rdata (loc_rdata),
    .busy      (busy),
    .done      (done),
    .loc_we    (loc_we),
    .loc_wdata (loc_wdata),
    .err_div0  (err_div0),
    .bad_index (bad_index)
);

// File: tb/recur_eval_test.sv
`timescale 1ns/1ps
module recur_eval_test;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] mem_word;
    logic          busy, done, loc_we, err_div0, bad_index;
    logic [DW-1:0] loc_wdata;
    logic          host_ld = 1'b0;
    logic [DW-1:0] host_val = '0;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int we_cnt = 0;

    typedef struct {
        logic [DW-1:0] val;
        logic          dz;
        logic          bi;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    recur_eval #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .loc_rdata(mem_word),
        .busy(busy), .done(done), .loc_we(loc_we), .loc_wdata(loc_wdata),
        .err_div0(err_div0), .bad_index(bad_index)
    );

    // one-word location
    always @(posedge clk) begin
        if (loc_we)       mem_word <= loc_wdata;
        else if (host_ld) mem_word <= host_val;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // independent model of the sequence
    function automatic exp_t model(input int k);
        exp_t e;
        int   t [0:64];
        e.dz = 1'b0; e.bi = 1'b0; e.tag = "R4";
        if (k == 0) begin e.val = '1; e.bi = 1'b1; e.tag = "R3"; return e; end
        t[1] = 2; t[2] = 1; t[3] = 3; t[4] = 4;
        if (k <= 4) begin e.val = DW'(t[k]); e.bi = 1'b1; e.tag = "R2"; return e; end
        for (int n = 4; n < k; n++) begin
            if (t[n-3] == 0) begin e.val = '1; e.dz = 1'b1; e.tag = "R6"; return e; end
            t[n+1] = (t[n] + t[n-1] + t[n-2]) / t[n-3];
        end
        e.val = DW'(t[k]);
        return e;
    endfunction

    // monitor: scoreboard compare at completion
    always @(negedge clk) begin
        if (loc_we) we_cnt++;
        if (done) begin
            done_cnt++;
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(loc_wdata == e.val, {e.tag, " result"}, loc_wdata, e.val);
                check(err_div0 == e.dz, "R6 err_div0", err_div0, e.dz);
                check(bad_index == e.bi, "R2/R3 bad_index", bad_index, e.bi);
                check(loc_we == 1'b1, "R5 we with done", loc_we, 1);
            end
        end
    end

    task automatic wait_done(input int base);
        int guard = 0;
        while (done_cnt == base && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(done_cnt > base, "R7 completion timeout", done_cnt, base + 1);
    endtask

    task automatic run_k(input int k);
        int   base, wbase;
        exp_t e;
        @(negedge clk);
        host_val = DW'(k); host_ld = 1'b1;
        @(negedge clk);
        host_ld = 1'b0;
        e = model(k);
        sb.push_back(e);
        base = done_cnt; wbase = we_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7 busy after start", busy, 1);
        if (k > 4) check(err_div0 == 0 && bad_index == 0, "R8 flags cleared", err_div0 + bad_index, 0);
        wait_done(base);
        @(negedge clk);
        check(busy == 1'b0, "R7 busy low after done", busy, 0);
        check(mem_word == e.val, "R5 location overwritten", mem_word, e.val);
        check(we_cnt - wbase == 1, "R5 single write", we_cnt - wbase, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && loc_we == 0, "R1 reset outputs", busy + done + loc_we, 0);
        check(err_div0 == 0 && bad_index == 0, "R1 reset flags", err_div0 + bad_index, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 1; k <= 4; k++) run_k(k);   // R2
        run_k(0);                               // R3
        run_k(5); run_k(6); run_k(7); run_k(10); run_k(16);  // R4
        run_k(17);                              // R6
        // R8: flags persist while idle
        repeat (5) @(negedge clk);
        check(err_div0 == 1'b1, "R8 err_div0 held", err_div0, 1);
        run_k(25);                              // R6 beyond first zero
        run_k(3);                               // R8 div0 cleared, bad_index set
        check(err_div0 == 1'b0, "R8 err_div0 cleared", err_div0, 0);

        // R7: start while busy is ignored
        begin
            int base, wbase;
            @(negedge clk);
            host_val = DW'(8); host_ld = 1'b1;
            @(negedge clk);
            host_ld = 1'b0;
            sb.push_back(model(8));
            base = done_cnt; wbase = we_cnt;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (6) @(negedge clk);
            host_val = DW'(6); host_ld = 1'b1;
            @(negedge clk);
            host_ld = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done(base);
            repeat (30) @(negedge clk);
            check(done_cnt - base == 1, "R7 ignored start no extra done", done_cnt - base, 1);
            check(mem_word == 16'd5, "R7 result of first k kept", mem_word, 5);
            check(we_cnt - wbase == 1, "R5 single write under restart", we_cnt - wbase, 1);
        end

        check(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule